// File: doc/BRIEF.md
# Peripheral Bridge With Access Timeout

This block lets two masters, a host and a DSP, reach one peripheral bus. The bus is split by a programmable address boundary. Addresses below the boundary belong to shared peripherals, which the host may use. Addresses at or above it belong to private peripherals, which only the DSP may use. A one-bit mode input selects between two operating modes:

- **Host-only mode:** only the host reaches the bus. Its transfers start on an enable strobe whose period is set by a programmable access factor.
- **Shared mode:** both masters are served. The host request is resynchronised through a flop chain. The DSP wins when both requests are pending. A host transfer already on the bus is never pre-empted.

Every host access is guarded by a timeout counter. The counter loads a programmable limit when the access starts and counts down while the peripheral holds ready low. When it reaches zero, the access is aborted, a one-cycle error pulse goes back to the host, and a sticky timeout flag is set. A host access to a private address never selects the bus; it runs into the same timeout. Each master holds its request and its address, write-enable and write-data fields stable until it sees an ack or an error pulse. It then drops the request before issuing another one.

Top module: `periph_bridge`

## Requirements
- R1: With mode=0 (host-only), a DSP request never selects the bus. It is answered with a one-cycle d_err pulse one clock after it is sampled, and no d_ack is given.
- R2: With mode=0, a host transfer starts only on an access strobe that occurs every acc_factor+1 clocks. With acc_factor=0 this is every clock, and a host read that finds ready high is acknowledged on the second clock edge after the request.
- R3: A host access whose address is greater than or equal to `boundary` never raises p_sel, in either mode. It ends in h_err, and no peripheral write occurs.
- R4: Once a host access starts, the timeout counter loads to_limit. If p_ready stays low, h_err pulses after to_limit+1 further clocks. to_flag becomes 1 with that pulse and stays 1 until reset.
- R5: With mode=1 (shared), when DSP and host requests are pending together, the DSP is served first and the host waits.
- R6: A host transfer that has already started on the bus completes before a DSP request is served. The bus address stays on the host address while it waits.
- R7: With mode=1, the host request passes through a SYNC_STAGES-deep synchroniser (2 by default), so a ready host read is acknowledged 2 clocks later than in host-only mode. A DSP read is acknowledged on the second edge.
- R8: On an acknowledged read, the requesting master's rdata holds the p_rdata value sampled with ready. On a write, p_addr, p_wdata and p_we carry the master's values.
- R9: ack and err are single-cycle pulses and never coincide for one master. A request held high after its completion is not served again until it has been dropped.
- R10: After reset, all acks, errors, p_sel and to_flag are 0.
- R11: With mode=1, the DSP may access private addresses and is acknowledged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | 0 = host-only, 1 = shared |
| acc_factor | input | FW | Host-only access strobe period minus one |
| to_limit | input | TW | Timeout load value for host accesses |
| boundary | input | AW | First private address |
| h_req | input | 1 | Host request |
| h_we | input | 1 | Host write enable |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_ack | output | 1 | Host completion pulse |
| h_err | output | 1 | Host timeout error pulse |
| h_rdata | output | DW | Host read data |
| d_req | input | 1 | DSP request |
| d_we | input | 1 | DSP write enable |
| d_addr | input | AW | DSP address |
| d_wdata | input | DW | DSP write data |
| d_ack | output | 1 | DSP completion pulse |
| d_err | output | 1 | DSP refused pulse (host-only mode) |
| d_rdata | output | DW | DSP read data |
| p_sel | output | 1 | Peripheral select |
| p_we | output | 1 | Peripheral write enable |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | DW | Peripheral write data |
| p_rdata | input | DW | Peripheral read data |
| p_ready | input | 1 | Peripheral ready |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with its defaults: AW=12, DW=16, TW=8, FW=3 and two synchroniser stages. This lets it set the boundary at 0x800, probe both 0x7FF and 0x800, and use a timeout limit of 5 for exact abort-cycle counts. A limit of 60 keeps stalled transfers alive for the arbitration tests. The 3-bit access factor allows a period-4 strobe whose start delay is bounded, and the two-stage synchroniser gives a fixed two-clock offset between shared-mode and host-only host latency.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOST = 2'd1,
      ST_DSP  = 2'd2
   } pbr_state_t;
endpackage

// File: rtl/pbr_strobe.sv
module pbr_strobe #(
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] factor,
   output logic          strobe
);
   logic [FW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (cnt == '0) cnt <= factor;
      else                cnt <= cnt - 1'b1;
   end

   assign strobe = (cnt == '0);
endmodule

// File: rtl/pbr_sync.sv
module pbr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= (r << 1) | STAGES'(d);
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pbr_timer.sv
module pbr_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= limit;
      else if (run && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = run && (cnt == '0);
endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
   import pbr_pkg::*;
#(
   parameter int AW          = 12,
   parameter int DW          = 16,
   parameter int TW          = 8,
   parameter int FW          = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode,
   input  logic [FW-1:0] acc_factor,
   input  logic [TW-1:0] to_limit,
   input  logic [AW-1:0] boundary,
   input  logic          h_req,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic          h_ack,
   output logic          h_err,
   output logic [DW-1:0] h_rdata,
   input  logic          d_req,
   input  logic          d_we,
   input  logic [AW-1:0] d_addr,
   input  logic [DW-1:0] d_wdata,
   output logic          d_ack,
   output logic          d_err,
   output logic [DW-1:0] d_rdata,
   output logic          p_sel,
   output logic          p_we,
   output logic [AW-1:0] p_addr,
   output logic [DW-1:0] p_wdata,
   input  logic [DW-1:0] p_rdata,
   input  logic          p_ready,
   output logic          to_flag
);
   generate
      if (AW < 2 || DW < 1 || TW < 1 || FW < 1) begin : g_bad_width
         $error("periph_bridge: widths must be positive, AW at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("periph_bridge: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   pbr_state_t    state;
   logic          strobe, hq_sync, hq;
   logic          h_hold, d_hold;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] lat_wdata;
   logic          lat_we, lat_priv;
   logic          host_go, dsp_go, dsp_deny;
   logic          start_h, start_d;
   logic          host_ok, host_abort, dsp_done;
   logic          tmr_run, tmr_exp;

   pbr_strobe #(.FW(FW)) i_strobe (
      .clk(clk), .rst_n(rst_n), .factor(acc_factor), .strobe(strobe)
   );

   pbr_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(h_req), .q(hq_sync)
   );

   // host request: resynchronised in shared mode, direct in host-only mode
   assign hq       = mode ? hq_sync : h_req;
   assign host_go  = hq && !h_hold && (mode || strobe);
   assign dsp_go   = mode && d_req && !d_hold;
   assign dsp_deny = !mode && d_req && !d_hold;

   assign start_d    = (state == ST_IDLE) && dsp_go;
   assign start_h    = (state == ST_IDLE) && !dsp_go && host_go;
   assign host_ok    = (state == ST_HOST) && p_ready && !lat_priv;
   assign tmr_run    = (state == ST_HOST) && !host_ok;
   assign host_abort = tmr_exp;
   assign dsp_done   = (state == ST_DSP) && p_ready;

   pbr_timer #(.TW(TW)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(start_h), .run(tmr_run),
      .limit(to_limit), .expired(tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_we    <= 1'b0;
         lat_priv  <= 1'b0;
         h_ack     <= 1'b0;
         h_err     <= 1'b0;
         d_ack     <= 1'b0;
         d_err     <= 1'b0;
         h_rdata   <= '0;
         d_rdata   <= '0;
         to_flag   <= 1'b0;
         h_hold    <= 1'b0;
         d_hold    <= 1'b0;
      end else begin
         h_ack   <= host_ok;
         h_err   <= host_abort;
         d_ack   <= dsp_done;
         d_err   <= dsp_deny;
         to_flag <= to_flag || host_abort;
         h_hold  <= host_ok || host_abort || (h_hold && hq);
         d_hold  <= dsp_done || dsp_deny || (d_hold && d_req);
         if (host_ok)  h_rdata <= p_rdata;
         if (dsp_done) d_rdata <= p_rdata;
         unique case (state)
            ST_IDLE: begin
               if (start_d) begin
                  state     <= ST_DSP;
                  lat_addr  <= d_addr;
                  lat_we    <= d_we;
                  lat_wdata <= d_wdata;
                  lat_priv  <= 1'b0;
               end else if (start_h) begin
                  state     <= ST_HOST;
                  lat_addr  <= h_addr;
                  lat_we    <= h_we;
                  lat_wdata <= h_wdata;
                  lat_priv  <= (h_addr >= boundary);
               end
            end
            ST_HOST: if (host_ok || host_abort) state <= ST_IDLE;
            ST_DSP:  if (dsp_done)              state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign p_sel   = ((state == ST_HOST) && !lat_priv) || (state == ST_DSP);
   assign p_we    = p_sel && lat_we;
   assign p_addr  = lat_addr;
   assign p_wdata = lat_wdata;
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker
   import pbr_pkg::*;
#(
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode,
   input logic [AW-1:0] boundary,
   input logic          h_ack,
   input logic          h_err,
   input logic          d_req,
   input logic          d_ack,
   input logic          d_hold,
   input logic          p_sel,
   input logic          p_ready,
   input logic [AW-1:0] p_addr,
   input logic          to_flag,
   input pbr_state_t    state
);
   p_no_dsp_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |-> !d_ack);
   p_hostonly_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && p_sel) |-> (state == ST_HOST));
   p_private_unselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (p_sel && state == ST_HOST) |-> (p_addr < boundary));
   p_err_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      h_err |-> to_flag);
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      to_flag |=> to_flag);
   p_dsp_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && mode && d_req && !d_hold) |=> (state == ST_DSP));
   p_bus_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (p_sel && !p_ready) |=> (!p_sel || $stable(p_addr)));
   p_hack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      h_ack |=> !h_ack);
   p_dack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      d_ack |=> !d_ack);
   p_ack_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_ack && h_err));
endmodule

bind periph_bridge pbr_checker #(.AW(AW)) i_pbr_checker (
   .clk(clk), .rst_n(rst_n), .mode(mode), .boundary(boundary),
   .h_ack(h_ack), .h_err(h_err), .d_req(d_req), .d_ack(d_ack),
   .d_hold(d_hold), .p_sel(p_sel), .p_ready(p_ready), .p_addr(p_addr),
   .to_flag(to_flag), .state(state)
);

// File: tb/test_periph_bridge.sv
`timescale 1ns/1ps
module test_periph_bridge;
   localparam int AW = 12, DW = 16, TW = 8, FW = 3;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          mode = 1'b0;
   logic [FW-1:0] acc_factor = '0;
   logic [TW-1:0] to_limit = 8'd5;
   logic [AW-1:0] boundary = 12'h800;
   logic          h_req = 0, h_we = 0, d_req = 0, d_we = 0;
   logic [AW-1:0] h_addr = '0, d_addr = '0;
   logic [DW-1:0] h_wdata = '0, d_wdata = '0;
   logic          h_ack, h_err, d_ack, d_err, p_sel, p_we, to_flag;
   logic [DW-1:0] h_rdata, d_rdata, p_wdata, p_rdata;
   logic [AW-1:0] p_addr;
   logic          rdy = 1'b1;

   int n_chk = 0, n_fail = 0;
   int wr_cnt = 0, sel_cnt = 0;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   always #10 clk = ~clk;

   periph_bridge i_periph_bridge (
      .clk(clk), .rst_n(rst_n), .mode(mode), .acc_factor(acc_factor),
      .to_limit(to_limit), .boundary(boundary),
      .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
      .h_ack(h_ack), .h_err(h_err), .h_rdata(h_rdata),
      .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
      .d_ack(d_ack), .d_err(d_err), .d_rdata(d_rdata),
      .p_sel(p_sel), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
      .p_rdata(p_rdata), .p_ready(rdy), .to_flag(to_flag)
   );

   // peripheral model
   assign p_rdata = {4'hA, p_addr};
   always @(posedge clk) begin
      if (p_sel) sel_cnt <= sel_cnt + 1;
      if (p_sel && p_we && rdy) begin
         wr_cnt  <= wr_cnt + 1;
         wr_addr <= p_addr;
         wr_data <= p_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic access(input bit dsp, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output bit err,
                         output logic [DW-1:0] rd, output int cyc);
      @(negedge clk);
      if (dsp) begin d_req = 1; d_we = we; d_addr = a; d_wdata = wd; end
      else     begin h_req = 1; h_we = we; h_addr = a; h_wdata = wd; end
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!(dsp ? (d_ack || d_err) : (h_ack || h_err)) && cyc < 200);
      err = dsp ? d_err : h_err;
      rd  = dsp ? d_rdata : h_rdata;
      h_req = 0; d_req = 0;
      repeat (4) @(negedge clk);
   endtask

   typedef struct packed {
      logic          mode;
      logic          dsp;
      logic          we;
      logic          exp_err;
      logic [11:0]   addr;
      logic [15:0]   wdata;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b0, 1'b0, 1'b0, 12'h010, 16'h0000},  // R8 host read
      '{1'b0, 1'b0, 1'b1, 1'b0, 12'h123, 16'hBEEF},  // R8 host write
      '{1'b0, 1'b0, 1'b1, 1'b1, 12'h900, 16'h1111},  // R3 private host
      '{1'b0, 1'b1, 1'b1, 1'b1, 12'h010, 16'h2222},  // R1 dsp refused
      '{1'b1, 1'b1, 1'b0, 1'b0, 12'h900, 16'h0000},  // R11 dsp private
      '{1'b1, 1'b0, 1'b0, 1'b0, 12'h7FF, 16'h0000},  // R3 boundary-1
      '{1'b1, 1'b0, 1'b1, 1'b1, 12'h800, 16'h3333},  // R3 boundary
      '{1'b1, 1'b1, 1'b1, 1'b0, 12'h055, 16'h1234}   // R8 dsp write
   };

   bit done = 0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit err;
      logic [DW-1:0] rd;
      int cyc, w0, s0, ht, dt;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!h_ack && !h_err && !d_ack && !d_err, "R10", "acks/errs", 0, 0);
      chk(!p_sel, "R10", "p_sel", p_sel, 0);
      chk(!to_flag, "R10", "to_flag", to_flag, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         mode = VEC[i].mode;
         w0 = wr_cnt; s0 = sel_cnt;
         access(VEC[i].dsp, VEC[i].we, VEC[i].addr, VEC[i].wdata, err, rd, cyc);
         chk(err == VEC[i].exp_err, "R1/R3/R8/R11", $sformatf("vec%0d err", i),
             err, VEC[i].exp_err);
         if (VEC[i].exp_err) begin
            chk(wr_cnt == w0, "R3", $sformatf("vec%0d no write", i), wr_cnt, w0);
            chk(sel_cnt == s0, "R1", $sformatf("vec%0d no select", i), sel_cnt, s0);
         end else if (VEC[i].we) begin
            chk(wr_addr == VEC[i].addr && wr_data == VEC[i].wdata, "R8",
                $sformatf("vec%0d write", i), wr_data, VEC[i].wdata);
         end else begin
            chk(rd == {4'hA, VEC[i].addr}, "R8", $sformatf("vec%0d rdata", i),
                rd, {4'hA, VEC[i].addr});
         end
         if (i == 2) chk(to_flag, "R4", "flag set", to_flag, 1);
      end
      chk(to_flag, "R4", "flag sticky", to_flag, 1);

      // R4 timeout cycle counts
      mode = 0;
      access(0, 0, 12'h900, 0, err, rd, cyc);
      chk(err && cyc == 7, "R4", "private abort cycles host-only", cyc, 7);
      rdy = 0;
      access(0, 0, 12'h010, 0, err, rd, cyc);
      chk(err && cyc == 7, "R4", "stall abort cycles", cyc, 7);
      rdy = 1;
      mode = 1;
      access(0, 0, 12'h900, 0, err, rd, cyc);
      chk(err && cyc == 9, "R4", "private abort cycles shared", cyc, 9);

      // R7 / R2 latencies
      mode = 0;
      access(0, 0, 12'h020, 0, err, rd, cyc);
      chk(!err && cyc == 2, "R2", "host-only latency", cyc, 2);
      mode = 1;
      access(0, 0, 12'h020, 0, err, rd, cyc);
      chk(!err && cyc == 4, "R7", "shared host latency", cyc, 4);
      access(1, 0, 12'h020, 0, err, rd, cyc);
      chk(!err && cyc == 2, "R7", "dsp latency", cyc, 2);
      mode = 0; acc_factor = 3;
      for (int k = 0; k < 4; k++) begin
         repeat (k) @(negedge clk);
         access(0, 0, 12'h030, 0, err, rd, cyc);
         chk(!err && cyc >= 2 && cyc <= 5, "R2", "strobed latency", cyc, 2);
      end
      acc_factor = 0;

      // R9 held request served once
      mode = 1;
      @(negedge clk);
      h_req = 1; h_we = 0; h_addr = 12'h040;
      cyc = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (h_ack) cyc++;
         if (h_ack && h_err) cyc += 100;
      end
      chk(cyc == 1, "R9", "single ack while held", cyc, 1);
      h_req = 0;
      repeat (4) @(negedge clk);

      // R5 simultaneous requests
      to_limit = 8'd60; rdy = 0;
      @(negedge clk);
      d_req = 1; d_we = 0; d_addr = 12'h050;
      h_req = 1; h_we = 0; h_addr = 12'h060;
      repeat (6) @(negedge clk);
      chk(p_addr == 12'h050, "R5", "dsp owns bus", p_addr, 12'h050);
      rdy = 1; ht = 0; dt = 0;
      for (int k = 1; k < 40; k++) begin
         @(negedge clk);
         if (h_ack && ht == 0) begin ht = k; h_req = 0; end
         if (d_ack && dt == 0) begin dt = k; d_req = 0; end
      end
      chk(dt != 0 && ht != 0 && dt < ht, "R5", "dsp before host", dt, ht);

      // R6 host started first completes first
      rdy = 0;
      @(negedge clk);
      h_req = 1; h_we = 0; h_addr = 12'h070;
      repeat (5) @(negedge clk);
      d_req = 1; d_we = 0; d_addr = 12'h080;
      repeat (4) @(negedge clk);
      chk(p_addr == 12'h070 && p_sel, "R6", "bus held by host", p_addr, 12'h070);
      rdy = 1; ht = 0; dt = 0;
      for (int k = 1; k < 40; k++) begin
         @(negedge clk);
         if (h_ack && ht == 0) begin ht = k; h_req = 0; end
         if (d_ack && dt == 0) begin dt = k; d_req = 0; end
      end
      chk(dt != 0 && ht != 0 && ht < dt, "R6", "host before dsp", ht, dt);
      chk(to_flag, "R4", "flag still set", to_flag, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule